// File: doc/BRIEF.md
# Flash Write-Status Polling Responder

This block is the device side of a parallel NOR-style memory while an internal program or erase is running. When the host issues the last write of a command sequence, the block latches the target. Until the operation ends, a read at a valid status address returns a status byte instead of array data. In that byte, bit 7 is the inverse of the value the target bit will finally hold. Bit 5 reports an operation that overran its cycle budget. The duration of a real operation comes from an external busy-timer model, which raises `op_done_i`. Fixed windows for commands aimed at protected sectors, and the overrun limit, are counted inside the block.

The array is a small register file of `2**ADDR_W` bytes, split into `2**SECT_W` equal sectors selected by the upper address bits. An erase can be suspended and resumed. While it is suspended, another location can be programmed. Reads at addresses that carry no status for the running operation return the stored byte.

Top module: `flash_poll_status`

## Requirements
- R1: A pulse on `cmd_done_i` with `cmd_op_i`=2'b00 (program) in idle, aimed at an unprotected sector, starts a program. From the next cycle, reads at that address return bit 7 = NOT `cmd_data_i[7]`, with bits 6 and 4..0 at 0.
- R2: If `op_done_i` is high at a clock edge during a program, the datum is written at that edge. Later reads at that address return the datum with its true bit 7. If the overrun limit is reached in that same cycle, completion wins.
- R3: `cmd_op_i`=2'b01 (erase) with a nonzero `cmd_mask_i` starts an erase. Reads in any selected sector (bit i = sector i, where sector = address bits [ADDR_W-1 -: SECT_W]) return 8'h00. After `op_done_i`, selected unprotected sectors read 8'hFF and protected ones are left unchanged.
- R4: While an erase runs, `susp_i`=1 suspends it from the next cycle. Reads in selected sectors then return bit 7 = 1, and `op_done_i` is ignored. Dropping `susp_i` resumes the erase. If `op_done_i` and a new `susp_i` arrive in the same cycle, the erase completes.
- R5: While an erase is suspended, a program to an unprotected sector runs and reports exactly as in R1/R2. On completion, the block returns to the suspended erase.
- R6: A program aimed at a protected sector (`prot_mask_i` bit set) shows status for 2*CLK_MHZ cycles, ignores `op_done_i`, and then returns to array reads with the data unchanged.
- R7: An erase whose selected sectors are all protected shows status for 100*CLK_MHZ cycles and then returns to array reads with the data unchanged.
- R8: During an operation, reads at an address that is not valid for it (not the program address, not in a selected erase sector) return the stored byte.
- R9: After TMO_CYC running cycles without completion, bit 5 of the status reads 1. The operation then freezes and ignores `op_done_i`. Only a reset command (`cmd_op_i`=2'b11) clears bit 5 and returns the block to idle.
- R10: While an operation runs normally, a new program or erase command is ignored, and so is a reset command.
- R11: After `rst_ni`, every byte reads 8'hFF. In idle, reads return the stored byte. `rd_data_o` is 8'h00 whenever `rd_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_done_i | input | 1 | One-cycle strobe: final write of a command sequence |
| cmd_op_i | input | 2 | 00 program, 01 erase, 11 reset, 10 none |
| cmd_addr_i | input | ADDR_W | Program address |
| cmd_data_i | input | 8 | Program datum |
| cmd_mask_i | input | 2**SECT_W | Sectors selected for erase |
| prot_mask_i | input | 2**SECT_W | Protected sectors |
| susp_i | input | 1 | Erase-suspend request (level) |
| op_done_i | input | 1 | Completion from the busy-timer model |
| rd_i | input | 1 | Read strobe |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | 8 | Read data or status byte |

## Verification
Two pairs of events can land in the same clock cycle.

- **Completion and suspend.** A running erase can receive `op_done_i` in the same cycle that `susp_i` first rises. The bench raises both together. It then judges that the erase took effect rather than the suspend: the sector reads 8'hFF and no status byte 8'h80 appears while `susp_i` is still high.
- **Completion and overrun.** A program can see `op_done_i` in the cycle where the overrun count expires. The bench places the done pulse on exactly that edge. It expects the written datum to read back with bit 5 clear.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;
  typedef enum logic [1:0] {
    OP_PROG  = 2'b00,
    OP_ERASE = 2'b01,
    OP_NONE  = 2'b10,
    OP_RESET = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG,
    ST_PROG_PROT,
    ST_ERASE,
    ST_ERASE_PROT,
    ST_SUSP,
    ST_SUSP_PROG
  } state_e;
endpackage

// File: rtl/flash_poll_array.sv
module flash_poll_array #(
  parameter int ADDR_W = 6,
  parameter int SECT_W = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [ADDR_W-1:0]       wr_addr_i,
  input  logic [7:0]              wr_data_i,
  input  logic                    ers_en_i,
  input  logic [(1<<SECT_W)-1:0]  ers_mask_i,
  input  logic [ADDR_W-1:0]       rd_addr_i,
  output logic [7:0]              rd_byte_o
);
  localparam int DEPTH    = 1 << ADDR_W;
  localparam int SECT_OFF = ADDR_W - SECT_W;

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else begin
      if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
      for (int i = 0; i < DEPTH; i++) begin
        if (ers_en_i && ers_mask_i[SECT_W'(i >> SECT_OFF)]) mem_q[i] <= 8'hFF;
      end
    end
  end

  assign rd_byte_o = mem_q[rd_addr_i];

  assert_wr_ers_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> !ers_en_i);

  assert_wr_lands_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> mem_q[$past(wr_addr_i)] == $past(wr_data_i));
endmodule

// File: rtl/flash_poll_timer.sv
module flash_poll_timer #(
  parameter int WIN_PROG  = 250,
  parameter int WIN_ERASE = 12500,
  parameter int TMO_CYC   = 16384
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic win_run_i,
  input  logic win_long_i,
  input  logic tmo_run_i,
  output logic win_end_o,
  output logic tmo_hit_o
);
  localparam int WIN_MAX = (WIN_ERASE > WIN_PROG) ? WIN_ERASE : WIN_PROG;
  localparam int WIN_W   = $clog2(WIN_MAX + 1);
  localparam int TMO_W   = $clog2(TMO_CYC + 1);

  logic [WIN_W-1:0] win_cnt_q, win_lim;
  logic [TMO_W-1:0] tmo_cnt_q;

  assign win_lim   = win_long_i ? WIN_W'(WIN_ERASE - 1) : WIN_W'(WIN_PROG - 1);
  assign win_end_o = win_run_i && (win_cnt_q == win_lim);
  assign tmo_hit_o = tmo_run_i && (tmo_cnt_q == TMO_W'(TMO_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_cnt_q <= '0;
      tmo_cnt_q <= '0;
    end else if (start_i) begin
      win_cnt_q <= '0;
      tmo_cnt_q <= '0;
    end else begin
      if (win_run_i) win_cnt_q <= win_cnt_q + 1'b1;
      if (tmo_run_i) tmo_cnt_q <= tmo_cnt_q + 1'b1;
    end
  end

  // window never runs past its limit (protected program R6, protected erase R7)
  assert_win_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_run_i |-> win_cnt_q <= win_lim);

  assert_tmo_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_run_i |-> tmo_cnt_q <= TMO_W'(TMO_CYC - 1));
endmodule

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl
  import flash_poll_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int SECT_W = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cmd_done_i,
  input  logic [1:0]              cmd_op_i,
  input  logic [ADDR_W-1:0]       cmd_addr_i,
  input  logic [7:0]              cmd_data_i,
  input  logic [(1<<SECT_W)-1:0]  cmd_mask_i,
  input  logic [(1<<SECT_W)-1:0]  prot_mask_i,
  input  logic                    susp_i,
  input  logic                    op_done_i,
  input  logic                    win_end_i,
  input  logic                    tmo_hit_i,
  output state_e                  state_o,
  output logic                    to_flag_o,
  output logic [ADDR_W-1:0]       tgt_addr_o,
  output logic [7:0]              tgt_data_o,
  output logic [(1<<SECT_W)-1:0]  sel_mask_o,
  output logic [(1<<SECT_W)-1:0]  ers_mask_o,
  output logic                    wr_en_o,
  output logic                    ers_en_o,
  output logic                    tstart_o,
  output logic                    win_run_o,
  output logic                    win_long_o,
  output logic                    tmo_run_o
);
  localparam int NSECT = 1 << SECT_W;

  state_e            st_q, st_d;
  logic              to_q, to_set, to_clr;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;
  logic [NSECT-1:0]  sel_q, live_q;
  logic              load_prog, load_ers;
  op_e               op;
  logic              prog_prot, is_reset;
  logic [NSECT-1:0]  live_d;

  assign op        = op_e'(cmd_op_i);
  assign prog_prot = prot_mask_i[cmd_addr_i[ADDR_W-1 -: SECT_W]];
  assign live_d    = cmd_mask_i & ~prot_mask_i;
  assign is_reset  = cmd_done_i && (op == OP_RESET);

  always_comb begin
    st_d      = st_q;
    load_prog = 1'b0;
    load_ers  = 1'b0;
    wr_en_o   = 1'b0;
    ers_en_o  = 1'b0;
    to_set    = 1'b0;
    to_clr    = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (cmd_done_i && op == OP_PROG) begin
          load_prog = 1'b1;
          st_d      = prog_prot ? ST_PROG_PROT : ST_PROG;
        end else if (cmd_done_i && op == OP_ERASE && |cmd_mask_i) begin
          load_ers = 1'b1;
          st_d     = (live_d == '0) ? ST_ERASE_PROT : ST_ERASE;
        end
      end
      ST_PROG, ST_SUSP_PROG: begin
        if (to_q) begin
          if (is_reset) begin
            to_clr = 1'b1;
            st_d   = ST_IDLE;
          end
        end else if (op_done_i) begin
          wr_en_o = 1'b1;
          st_d    = (st_q == ST_PROG) ? ST_IDLE : ST_SUSP;
        end else if (tmo_hit_i) begin
          to_set = 1'b1;
        end
      end
      ST_ERASE: begin
        if (to_q) begin
          if (is_reset) begin
            to_clr = 1'b1;
            st_d   = ST_IDLE;
          end
        end else if (op_done_i) begin
          // completion outranks a suspend arriving in the same cycle
          ers_en_o = 1'b1;
          st_d     = ST_IDLE;
        end else if (susp_i) begin
          st_d = ST_SUSP;
        end else if (tmo_hit_i) begin
          to_set = 1'b1;
        end
      end
      ST_SUSP: begin
        if (!susp_i) begin
          st_d = ST_ERASE;
        end else if (cmd_done_i && op == OP_PROG && !prog_prot) begin
          load_prog = 1'b1;
          st_d      = ST_SUSP_PROG;
        end
      end
      ST_PROG_PROT, ST_ERASE_PROT: begin
        if (win_end_i) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      to_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      sel_q  <= '0;
      live_q <= '0;
    end else begin
      st_q <= st_d;
      if (to_set) to_q <= 1'b1;
      else if (to_clr) to_q <= 1'b0;
      if (load_prog) begin
        addr_q <= cmd_addr_i;
        data_q <= cmd_data_i;
      end
      if (load_ers) begin
        sel_q  <= cmd_mask_i;
        live_q <= live_d;
      end
    end
  end

  assign state_o    = st_q;
  assign to_flag_o  = to_q;
  assign tgt_addr_o = addr_q;
  assign tgt_data_o = data_q;
  assign sel_mask_o = sel_q;
  assign ers_mask_o = live_q;
  assign tstart_o   = (st_d != st_q);
  assign win_run_o  = (st_q == ST_PROG_PROT) || (st_q == ST_ERASE_PROT);
  assign win_long_o = (st_q == ST_ERASE_PROT);
  assign tmo_run_o  = !to_q && ((st_q == ST_PROG) || (st_q == ST_ERASE) ||
                                (st_q == ST_SUSP_PROG));

  assert_prog_start_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && cmd_done_i && op == OP_PROG && !prog_prot)
      |=> (st_q == ST_PROG) && (addr_q == $past(cmd_addr_i)));

  assert_resume_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SUSP && !susp_i) |=> st_q == ST_ERASE);

  assert_to_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (to_q && !is_reset) |=> to_q);

  assert_to_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    to_q |-> st_q != ST_IDLE);

  assert_busy_ignore_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE && cmd_done_i && op == OP_ERASE) |=> $stable(sel_q));
endmodule

// File: rtl/flash_poll_status.sv
module flash_poll_status
  import flash_poll_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int SECT_W  = 2,
  parameter int CLK_MHZ = 125,
  parameter int TMO_CYC = 16384
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cmd_done_i,
  input  logic [1:0]              cmd_op_i,
  input  logic [ADDR_W-1:0]       cmd_addr_i,
  input  logic [7:0]              cmd_data_i,
  input  logic [(1<<SECT_W)-1:0]  cmd_mask_i,
  input  logic [(1<<SECT_W)-1:0]  prot_mask_i,
  input  logic                    susp_i,
  input  logic                    op_done_i,
  input  logic                    rd_i,
  input  logic [ADDR_W-1:0]       rd_addr_i,
  output logic [7:0]              rd_data_o
);
  localparam int NSECT     = 1 << SECT_W;
  localparam int WIN_PROG  = 2 * CLK_MHZ;
  localparam int WIN_ERASE = 100 * CLK_MHZ;

  state_e            st;
  logic              to_flag, wr_en, ers_en, tstart;
  logic              win_run, win_long, tmo_run, win_end, tmo_hit;
  logic [ADDR_W-1:0] tgt_addr;
  logic [7:0]        tgt_data, arr_byte;
  logic [NSECT-1:0]  sel_mask, ers_mask;

  flash_poll_ctrl #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_ctrl (
    .clk_i, .rst_ni, .cmd_done_i, .cmd_op_i, .cmd_addr_i, .cmd_data_i,
    .cmd_mask_i, .prot_mask_i, .susp_i, .op_done_i,
    .win_end_i (win_end),
    .tmo_hit_i (tmo_hit),
    .state_o   (st),
    .to_flag_o (to_flag),
    .tgt_addr_o(tgt_addr),
    .tgt_data_o(tgt_data),
    .sel_mask_o(sel_mask),
    .ers_mask_o(ers_mask),
    .wr_en_o   (wr_en),
    .ers_en_o  (ers_en),
    .tstart_o  (tstart),
    .win_run_o (win_run),
    .win_long_o(win_long),
    .tmo_run_o (tmo_run)
  );

  flash_poll_timer #(.WIN_PROG(WIN_PROG), .WIN_ERASE(WIN_ERASE), .TMO_CYC(TMO_CYC)) u_timer (
    .clk_i, .rst_ni,
    .start_i   (tstart),
    .win_run_i (win_run),
    .win_long_i(win_long),
    .tmo_run_i (tmo_run),
    .win_end_o (win_end),
    .tmo_hit_o (tmo_hit)
  );

  flash_poll_array #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_array (
    .clk_i, .rst_ni,
    .wr_en_i   (wr_en),
    .wr_addr_i (tgt_addr),
    .wr_data_i (tgt_data),
    .ers_en_i  (ers_en),
    .ers_mask_i(ers_mask),
    .rd_addr_i,
    .rd_byte_o (arr_byte)
  );

  logic             va, b7;
  logic             in_sel;
  logic [7:0]       status;

  assign in_sel = sel_mask[rd_addr_i[ADDR_W-1 -: SECT_W]];

  always_comb begin
    va = 1'b0;
    b7 = 1'b0;
    unique case (st)
      ST_PROG, ST_PROG_PROT, ST_SUSP_PROG: begin
        va = (rd_addr_i == tgt_addr);
        b7 = ~tgt_data[7];
      end
      ST_ERASE, ST_ERASE_PROT: begin
        va = in_sel;
        b7 = 1'b0;
      end
      ST_SUSP: begin
        va = in_sel;
        b7 = 1'b1;
      end
      default: ;
    endcase
  end

  assign status    = {b7, 1'b0, to_flag, 5'b0};
  assign rd_data_o = !rd_i ? 8'h00 : (va ? status : arr_byte);

  // a pure array read may never carry the overrun bit into the idle state
  assert_idle_clean_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_IDLE) |-> !to_flag);
endmodule

// File: tb/flash_poll_status_tb_top.sv
module flash_poll_status_tb_top;
  localparam int ADDR_W  = 6;
  localparam int SECT_W  = 2;
  localparam int CLK_MHZ = 125;
  localparam int TMO_CYC = 16384;
  localparam int WIN_P   = 2 * CLK_MHZ;
  localparam int WIN_E   = 100 * CLK_MHZ;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_done_i = 1'b0;
  logic [1:0]  cmd_op_i = 2'b10;
  logic [5:0]  cmd_addr_i = '0;
  logic [7:0]  cmd_data_i = '0;
  logic [3:0]  cmd_mask_i = '0;
  logic [3:0]  prot_mask_i = '0;
  logic        susp_i = 1'b0;
  logic        op_done_i = 1'b0;
  logic        rd_i = 1'b0;
  logic [5:0]  rd_addr_i = '0;
  logic [7:0]  rd_data_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk_i = ~clk_i;

  flash_poll_status #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .CLK_MHZ(CLK_MHZ),
                      .TMO_CYC(TMO_CYC)) dut_i (.*);

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic chk_rd(input string tag, input logic [5:0] a, input logic [7:0] exp);
    rd_addr_i = a;
    rd_i = 1'b1;
    #1;
    check(tag, rd_data_o, exp);
    rd_i = 1'b0;
  endtask

  task automatic cmd(input logic [1:0] op, input logic [5:0] a, input logic [7:0] d,
                     input logic [3:0] m);
    cmd_op_i = op; cmd_addr_i = a; cmd_data_i = d; cmd_mask_i = m;
    cmd_done_i = 1'b1;
    @(negedge clk_i);
    cmd_done_i = 1'b0;
    cmd_op_i = 2'b10;
  endtask

  task automatic done_pulse();
    op_done_i = 1'b1;
    @(negedge clk_i);
    op_done_i = 1'b0;
  endtask

  task automatic prog_now(input logic [5:0] a, input logic [7:0] d);
    cmd(2'b00, a, d, 4'h0);
    done_pulse();
  endtask

  task automatic t_reset();
    chk_rd("R11 reset byte 00", 6'h00, 8'hFF);
    chk_rd("R11 reset byte 3F", 6'h3F, 8'hFF);
    rd_addr_i = 6'h00; rd_i = 1'b0; #1;
    check("R11 rd_i low", rd_data_o, 8'h00);
  endtask

  task automatic t_program();
    cmd(2'b00, 6'h05, 8'h3C, 4'h0);
    chk_rd("R1 status inverted b7", 6'h05, 8'h80);
    chk_rd("R8 non-VA array read", 6'h06, 8'hFF);
    cmd(2'b01, 6'h00, 8'h00, 4'h1);
    chk_rd("R10 erase ignored", 6'h05, 8'h80);
    cmd(2'b11, 6'h00, 8'h00, 4'h0);
    chk_rd("R10 reset ignored", 6'h05, 8'h80);
    done_pulse();
    chk_rd("R2 datum written", 6'h05, 8'h3C);
    cmd(2'b00, 6'h07, 8'hA5, 4'h0);
    chk_rd("R1 status b7 one datum", 6'h07, 8'h00);
    done_pulse();
    chk_rd("R2 datum A5", 6'h07, 8'hA5);
  endtask

  task automatic t_erase_mixed();
    prot_mask_i = 4'h0;
    prog_now(6'h25, 8'h11);
    prot_mask_i = 4'h4;
    prog_now(6'h15, 8'h22);
    cmd(2'b01, 6'h00, 8'h00, 4'b0101);
    chk_rd("R3 erase status sector0", 6'h05, 8'h00);
    chk_rd("R3 erase status protected sel", 6'h25, 8'h00);
    chk_rd("R8 erase non-selected", 6'h15, 8'h22);
    done_pulse();
    chk_rd("R3 erased 05", 6'h05, 8'hFF);
    chk_rd("R3 erased 07", 6'h07, 8'hFF);
    chk_rd("R3 protected kept", 6'h25, 8'h11);
    chk_rd("R3 unselected kept", 6'h15, 8'h22);
  endtask

  task automatic t_suspend();
    prog_now(6'h01, 8'h00);
    cmd(2'b01, 6'h00, 8'h00, 4'b0001);
    chk_rd("R3 erase running", 6'h01, 8'h00);
    susp_i = 1'b1;
    @(negedge clk_i);
    chk_rd("R4 suspended b7", 6'h01, 8'h80);
    done_pulse();
    chk_rd("R4 done ignored in suspend", 6'h01, 8'h80);
    cmd(2'b00, 6'h12, 8'h7E, 4'h0);
    chk_rd("R5 program in suspend status", 6'h12, 8'h80);
    done_pulse();
    chk_rd("R5 program in suspend data", 6'h12, 8'h7E);
    chk_rd("R5 back to suspended erase", 6'h01, 8'h80);
    susp_i = 1'b0;
    @(negedge clk_i);
    chk_rd("R4 resumed", 6'h01, 8'h00);
    done_pulse();
    chk_rd("R4 erase completes after resume", 6'h01, 8'hFF);
  endtask

  task automatic t_same_cycle();
    prog_now(6'h02, 8'h10);
    cmd(2'b01, 6'h00, 8'h00, 4'b0001);
    susp_i = 1'b1;
    done_pulse();
    chk_rd("R4 done beats suspend", 6'h02, 8'hFF);
    chk_rd("R4 no suspend after done", 6'h03, 8'hFF);
    susp_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic t_prot_program();
    cmd(2'b00, 6'h22, 8'h00, 4'h0);
    chk_rd("R6 protected status", 6'h22, 8'h80);
    done_pulse();
    repeat (WIN_P - 2) @(negedge clk_i);
    chk_rd("R6 window last cycle", 6'h22, 8'h80);
    @(negedge clk_i);
    chk_rd("R6 back to array unchanged", 6'h22, 8'hFF);
  endtask

  task automatic t_prot_erase();
    cmd(2'b01, 6'h00, 8'h00, 4'b0100);
    chk_rd("R7 protected erase status", 6'h25, 8'h00);
    repeat (WIN_E - 1) @(negedge clk_i);
    chk_rd("R7 window last cycle", 6'h25, 8'h00);
    @(negedge clk_i);
    chk_rd("R7 back to array unchanged", 6'h25, 8'h11);
  endtask

  task automatic t_timeout();
    cmd(2'b00, 6'h30, 8'h55, 4'h0);
    repeat (TMO_CYC - 1) @(negedge clk_i);
    chk_rd("R9 flag clear before limit", 6'h30, 8'h80);
    @(negedge clk_i);
    chk_rd("R9 flag set at limit", 6'h30, 8'hA0);
    done_pulse();
    chk_rd("R9 done ignored after overrun", 6'h30, 8'hA0);
    cmd(2'b01, 6'h00, 8'h00, 4'h1);
    chk_rd("R10 erase ignored in overrun", 6'h30, 8'hA0);
    cmd(2'b11, 6'h00, 8'h00, 4'h0);
    chk_rd("R9 reset clears, no write", 6'h30, 8'hFF);
    cmd(2'b00, 6'h31, 8'h5A, 4'h0);
    repeat (TMO_CYC - 1) @(negedge clk_i);
    done_pulse();
    chk_rd("R2 done beats overrun", 6'h31, 8'h5A);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_program();
    t_erase_mixed();
    t_suspend();
    t_same_cycle();
    t_prot_program();
    t_prot_erase();
    t_timeout();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule